// File: doc/BRIEF.md
# Interrupt Moderation Controller for a Network Interface

This block sits between the receive and transmit paths of a network controller and the host interrupt line. Cause pulses from the datapath and from four internal delay timers set bits in a sticky pending register. A mask register selects which pending bits may drive the line. A throttle timer holds off assertion of the line for a set interval after each assertion. An urgent post can bypass that hold-off.

Each direction has two delay timers. The packet timer restarts on every packet event. The absolute timer starts on the first event and is not restarted while it runs. When either timer of a direction expires, the block stops both timers of that direction. It then pulses a descriptor writeback request for that direction and posts the cause bit of that direction. All intervals count in ticks. One tick is `TICK_DIV` clocks, which should be chosen as 1024 ns at the clock in use. A delay or throttle value of zero disables that timer.

The host reads the pending register from `pend_q` and pulses `pend_rd` to clear it. Writing the mask re-evaluates the line at once.

Top module: `irq_pacer`

## Requirements
- R1: After reset, `irq`, `rx_wb_req`, `tx_wb_req` and `pend_q` are 0 and the mask is all zeros, so a posted cause leaves `irq` low.
- R2: A bit of `cause_set` sampled at a clock edge appears in `pend_q` after that edge and stays until a `pend_rd` pulse. `pend_rd` clears every bit except those being set in the same cycle.
- R3: When a cause is set in a bit whose mask bit is 1 and no throttle interval is running, `irq` rises two clocks after the cause is sampled. It then stays high while any unmasked pending bit remains.
- R4: A mask write that unmasks a pending bit raises `irq` two clocks after the write. A mask write that masks every pending bit drops `irq` two clocks after the write.
- R5: When `pend_rd` leaves no unmasked pending bit, `irq` falls two clocks after `pend_rd` is sampled.
- R6: The receive packet timer reloads with `rx_pkt_dly` on each `rx_pkt`. After `rx_pkt_dly` ticks without a new event it expires. On expiry `rx_wb_req` pulses for one clock and pending bit `RXT_BIT` (default bit 1) is set.
- R7: The receive absolute timer loads `rx_abs_dly` only when idle and is not restarted by later `rx_pkt` events. Its expiry has the same effect as in R6. Expiry of either receive timer stops both receive timers.
- R8: Expiry of either transmit timer pulses `tx_wb_req` for one clock and sets pending bit `TXD_BIT` (default bit 0). The transmit timers follow the same restart rules as the receive timers, using `tx_pkt`, `tx_pkt_dly` and `tx_abs_dly`.
- R9: Each rise of `irq` starts the throttle timer for `thr_ival` ticks. While it runs, a newly unmasked cause is held. The cause is asserted on the clock at which the throttle interval ends.
- R10: A `cause_set` pulse accompanied by `cause_now` raises `irq` two clocks later even while the throttle timer runs.
- R11: A delay input of zero disables its timer, so packet events produce no writeback request from it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cause_set | input | NC | One-cycle cause posts from the datapath |
| cause_now | input | 1 | Marks the current post as urgent (bypass throttle) |
| rx_pkt | input | 1 | Receive packet event |
| tx_pkt | input | 1 | Transmit packet event |
| rx_pkt_dly | input | TW | Receive packet timer interval in ticks |
| rx_abs_dly | input | TW | Receive absolute timer interval in ticks |
| tx_pkt_dly | input | TW | Transmit packet timer interval in ticks |
| tx_abs_dly | input | TW | Transmit absolute timer interval in ticks |
| thr_ival | input | TW | Minimum ticks between interrupt assertions |
| mask_wr | input | 1 | Mask write strobe |
| mask_wdata | input | NC | New mask value |
| pend_rd | input | 1 | Read-and-clear of the pending register |
| pend_q | output | NC | Pending cause register |
| irq | output | 1 | Interrupt line to the host |
| rx_wb_req | output | 1 | One-cycle receive descriptor writeback request |
| tx_wb_req | output | 1 | One-cycle transmit descriptor writeback request |

## Verification
The bench drives a steady packet stream into the receive timers. A design that restarted the absolute timer would never flush. A design that left the packet timer running after the absolute expiry would issue a second, spurious writeback. The bench then releases the host's read-clear while the throttle runs and posts again. It checks that the line stays low until the exact tick at which the hold-off ends: a design that ignored the throttle rises early, and one with an off-by-one interval rises late. An urgent post inside a running hold-off must raise the line at once. Mask writes over already-pending bits must raise and drop the line without any new cause, which catches a design that evaluates the mask only when a cause arrives.

// File: rtl/irq_pacer.sv
module irq_pacer #(
  parameter int NC       = 8,
  parameter int TW       = 16,
  parameter int TICK_DIV = 51,
  parameter int RXT_BIT  = 1,
  parameter int TXD_BIT  = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NC-1:0] cause_set,
  input  logic          cause_now,
  input  logic          rx_pkt,
  input  logic          tx_pkt,
  input  logic [TW-1:0] rx_pkt_dly,
  input  logic [TW-1:0] rx_abs_dly,
  input  logic [TW-1:0] tx_pkt_dly,
  input  logic [TW-1:0] tx_abs_dly,
  input  logic [TW-1:0] thr_ival,
  input  logic          mask_wr,
  input  logic [NC-1:0] mask_wdata,
  input  logic          pend_rd,
  output logic [NC-1:0] pend_q,
  output logic          irq,
  output logic          rx_wb_req,
  output logic          tx_wb_req
);
  localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  logic [PW-1:0] pre;
  wire tick = (pre == PW'(TICK_DIV - 1));

  always_ff @(posedge clk)
    if (!rst_n) pre <= '0;
    else        pre <= tick ? '0 : pre + 1'b1;

  logic [TW-1:0] dly [4];
  logic [3:0] ev, exp_t, stop;
  assign dly[0] = rx_pkt_dly;
  assign dly[1] = rx_abs_dly;
  assign dly[2] = tx_pkt_dly;
  assign dly[3] = tx_abs_dly;
  assign ev     = {tx_pkt, tx_pkt, rx_pkt, rx_pkt};

  wire rx_exp = exp_t[0] | exp_t[1];
  wire tx_exp = exp_t[2] | exp_t[3];
  assign stop = {tx_exp, tx_exp, rx_exp, rx_exp};

  for (genvar i = 0; i < 4; i++) begin : g_tmr
    localparam bit RESTART = (i % 2 == 0);
    logic          run;
    logic [TW-1:0] cnt;
    assign exp_t[i] = run & tick & (cnt <= TW'(1));
    always_ff @(posedge clk)
      if (!rst_n) begin
        run <= 1'b0;
        cnt <= '0;
      end else if (ev[i] && dly[i] != '0 && (RESTART || !run || stop[i])) begin
        run <= 1'b1;
        cnt <= dly[i];
      end else if (stop[i]) begin
        run <= 1'b0;
      end else if (run && tick) begin
        cnt <= cnt - 1'b1;
      end
  end

  logic [NC-1:0] mask_q;
  logic [NC-1:0] tmr_set;
  logic          now_q;
  assign tmr_set = (NC'(rx_exp) << RXT_BIT) | (NC'(tx_exp) << TXD_BIT);

  always_ff @(posedge clk)
    if (!rst_n) begin
      pend_q    <= '0;
      mask_q    <= '0;
      now_q     <= 1'b0;
      rx_wb_req <= 1'b0;
      tx_wb_req <= 1'b0;
    end else begin
      pend_q    <= (pend_rd ? '0 : pend_q) | cause_set | tmr_set;
      if (mask_wr) mask_q <= mask_wdata;
      now_q     <= cause_now & (|cause_set);
      rx_wb_req <= rx_exp;
      tx_wb_req <= tx_exp;
    end

  logic          thr_run;
  logic [TW-1:0] thr_cnt;
  wire thr_exp = thr_run & tick & (thr_cnt <= TW'(1));
  wire active  = |(pend_q & mask_q);
  wire fire    = active & ~irq & (~thr_run | thr_exp | now_q);

  always_ff @(posedge clk)
    if (!rst_n) begin
      irq     <= 1'b0;
      thr_run <= 1'b0;
      thr_cnt <= '0;
    end else begin
      irq <= active & (irq | fire);
      if (fire && thr_ival != '0) begin
        thr_run <= 1'b1;
        thr_cnt <= thr_ival;
      end else if (thr_exp) begin
        thr_run <= 1'b0;
      end else if (thr_run && tick) begin
        thr_cnt <= thr_cnt - 1'b1;
      end
    end
endmodule

// File: rtl/irq_pacer_chk.sv
module irq_pacer_chk #(
  parameter int NC      = 8,
  parameter int RXT_BIT = 1,
  parameter int TXD_BIT = 0
) (
  input logic          clk,
  input logic          rst_n,
  input logic          irq,
  input logic          rx_wb_req,
  input logic          tx_wb_req,
  input logic          pend_rd,
  input logic [NC-1:0] pend_q,
  input logic [NC-1:0] mask_q
);
  AST_RXWB_POSTS: assert property (@(posedge clk) disable iff (!rst_n)
    rx_wb_req |-> pend_q[RXT_BIT]); // R6
  AST_TXWB_POSTS: assert property (@(posedge clk) disable iff (!rst_n)
    tx_wb_req |-> pend_q[TXD_BIT]); // R8
  AST_IRQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(|(pend_q & mask_q))); // R5
  AST_MASKED_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(pend_q & mask_q)) |=> !irq); // R4
  AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_rd |=> ((pend_q & $past(pend_q)) == $past(pend_q))); // R2
  AST_IRQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && (|(pend_q & mask_q))) |=> irq); // R3
endmodule

bind irq_pacer irq_pacer_chk #(.NC(NC), .RXT_BIT(RXT_BIT), .TXD_BIT(TXD_BIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq(irq), .rx_wb_req(rx_wb_req),
  .tx_wb_req(tx_wb_req), .pend_rd(pend_rd), .pend_q(pend_q), .mask_q(mask_q));

// File: tb/irq_pacer_bench.sv
`timescale 1ns/1ps
module irq_pacer_bench;
  localparam int NC = 8, TW = 16;
  logic clk = 0, rst_n = 0;
  logic [NC-1:0] cause_set = '0, mask_wdata = '0, pend_q;
  logic cause_now = 0, rx_pkt = 0, tx_pkt = 0, mask_wr = 0, pend_rd = 0;
  logic [TW-1:0] rx_pkt_dly = '0, rx_abs_dly = '0, tx_pkt_dly = '0, tx_abs_dly = '0, thr_ival = '0;
  logic irq, rx_wb_req, tx_wb_req;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  irq_pacer #(.NC(NC), .TW(TW), .TICK_DIV(1)) u_irq_pacer (
    .clk(clk), .rst_n(rst_n), .cause_set(cause_set), .cause_now(cause_now),
    .rx_pkt(rx_pkt), .tx_pkt(tx_pkt), .rx_pkt_dly(rx_pkt_dly), .rx_abs_dly(rx_abs_dly),
    .tx_pkt_dly(tx_pkt_dly), .tx_abs_dly(tx_abs_dly), .thr_ival(thr_ival),
    .mask_wr(mask_wr), .mask_wdata(mask_wdata), .pend_rd(pend_rd),
    .pend_q(pend_q), .irq(irq), .rx_wb_req(rx_wb_req), .tx_wb_req(tx_wb_req));

  // {mask, cause, expected irq}
  localparam logic [16:0] VEC [6] = '{
    {8'hFF, 8'h04, 1'b1}, {8'h00, 8'h04, 1'b0}, {8'hF0, 8'h0F, 1'b0},
    {8'h0F, 8'h08, 1'b1}, {8'h80, 8'h81, 1'b1}, {8'h7E, 8'h81, 1'b0}};

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_mask(input logic [NC-1:0] m);
    mask_wr = 1; mask_wdata = m; step(1); mask_wr = 0;
  endtask

  task automatic clear_all();
    pend_rd = 1; step(1); pend_rd = 0; step(3);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    finish_run();
  end

  initial begin
    int seen;
    step(3); rst_n = 1; step(1);
    chk(irq == 0, "R1 irq", irq, 0);
    chk(pend_q == 0, "R1 pend", pend_q, 0);
    chk(!rx_wb_req && !tx_wb_req, "R1 wb", {rx_wb_req, tx_wb_req}, 0);
    cause_set = 8'h10; step(1); cause_set = 0; step(1);
    chk(irq == 0, "R1 mask reset masks all", irq, 0);
    chk(pend_q == 8'h10, "R2 pend set", pend_q, 8'h10);
    step(5);
    chk(pend_q == 8'h10, "R2 pend sticky", pend_q, 8'h10);

    foreach (VEC[i]) begin
      mask_wr = 1; mask_wdata = VEC[i][16:9]; pend_rd = 1; step(1);
      mask_wr = 0; pend_rd = 0; step(2);
      cause_set = VEC[i][8:1]; step(1); cause_set = 0;
      chk(pend_q == VEC[i][8:1], "R2 vector pend", pend_q, VEC[i][8:1]);
      step(1);
      chk(irq == VEC[i][0], "R3 vector irq", irq, VEC[i][0]);
    end

    set_mask(8'h00); clear_all();
    cause_set = 8'h08; step(1); cause_set = 0; step(3);
    chk(irq == 0, "R4 masked cause", irq, 0);
    mask_wr = 1; mask_wdata = 8'h08; step(1); mask_wr = 0; step(1);
    chk(irq == 1, "R4 unmask raises", irq, 1);
    mask_wr = 1; mask_wdata = 8'h00; step(1); mask_wr = 0; step(1);
    chk(irq == 0, "R4 mask drops", irq, 0);

    set_mask(8'hFF); clear_all();
    rx_pkt_dly = 4; rx_abs_dly = 0;
    rx_pkt = 1; step(1); rx_pkt = 0; step(1); rx_pkt = 1; step(1); rx_pkt = 0; step(3);
    chk(rx_wb_req == 0, "R6 restart delays expiry", rx_wb_req, 0);
    step(1);
    chk(rx_wb_req == 1, "R6 expiry wb", rx_wb_req, 1);
    chk(pend_q[1] == 1, "R6 cause bit1", pend_q, 8'h02);
    step(1);
    chk(irq == 1, "R6 irq", irq, 1);
    chk(rx_wb_req == 0, "R6 wb one cycle", rx_wb_req, 0);
    clear_all();

    rx_abs_dly = 10;
    for (int k = 0; k < 12; k++) begin
      if (k == 10) chk(rx_wb_req == 0, "R7 abs not early", rx_wb_req, 0);
      if (k == 11) chk(rx_wb_req == 1, "R7 abs expiry", rx_wb_req, 1);
      rx_pkt = (k % 3 == 0) && (k <= 9);
      step(1);
    end
    rx_pkt = 0;
    seen = 0;
    for (int k = 0; k < 10; k++) begin
      if (rx_wb_req) seen++;
      step(1);
    end
    chk(seen == 0, "R7 both rx timers stopped", seen, 0);
    clear_all();

    rx_pkt_dly = 0; rx_abs_dly = 0; seen = 0;
    rx_pkt = 1; step(1); rx_pkt = 0;
    for (int k = 0; k < 8; k++) begin
      if (rx_wb_req) seen++;
      step(1);
    end
    chk(seen == 0, "R11 zero delay disables", seen, 0);

    tx_abs_dly = 3; tx_pkt_dly = 0;
    tx_pkt = 1; step(1); tx_pkt = 0; step(2);
    chk(tx_wb_req == 0, "R8 tx not early", tx_wb_req, 0);
    step(1);
    chk(tx_wb_req == 1, "R8 tx expiry", tx_wb_req, 1);
    chk(pend_q[0] == 1, "R8 cause bit0", pend_q, 8'h01);
    tx_abs_dly = 0; step(2); clear_all();

    thr_ival = 5;
    cause_set = 8'h04; step(1); cause_set = 0; step(1);
    chk(irq == 1, "R3 first assert", irq, 1);
    pend_rd = 1; step(1); pend_rd = 0; step(1);
    chk(irq == 0, "R5 read clear drops", irq, 0);
    cause_set = 8'h04; step(1); cause_set = 0; step(1);
    chk(irq == 0, "R9 held by throttle", irq, 0);
    step(1);
    chk(irq == 1, "R9 asserted at throttle end", irq, 1);
    pend_rd = 1; step(1); pend_rd = 0; step(1);
    chk(irq == 0, "R5 drop again", irq, 0);
    cause_set = 8'h04; cause_now = 1; step(1); cause_set = 0; cause_now = 0; step(1);
    chk(irq == 1, "R10 urgent bypass", irq, 1);

    finish_run();
  end
endmodule